// File: doc/BRIEF.md
# Key-Locked Configuration Port

This block gives a host a small configuration space behind two byte-wide I/O addresses: an index port at a parameterised address and a data port one address above it. The space is normally locked. A host unlocks it by writing an opening key to the index port. While it is unlocked, the index port selects a register and the data port reads or writes that register. A closing key written to the index port locks the space again.

Inside the space there is a selector for the logical device, a fixed identification byte, and a revision byte. For the single modelled logical device, the mailbox, there is also an activate register and a 16-bit base address. The activate bit and the base address are held in registers that drive the rest of the chip directly. The host bus timing is abstracted to single-cycle read and write strobes with an address. Read data is registered and can be seen after the clock edge that accepted the read.

Top module: `cfgp_top`

## Requirements
- R1: After reset the space is locked, the selected logical device is 0, `mbx_active` is 0 and `mbx_base` equals the parameter `MBX_BASE_RST` (default 0x0800).
- R2: While locked, writing 0x55 to the index port unlocks the space. Any other value written there while locked changes nothing, and the stored index keeps its previous value (0x00 after reset).
- R3: While unlocked, a read of the index port returns the last index written. Writing 0xAA to the index port locks the space, after which index reads return 0xFF.
- R4: The data port sits at the index address plus one. While locked, data-port writes are ignored and data-port reads return 0xFF.
- R5: Index 0x20 reads the identification byte 0x4D and index 0x21 reads the parameter `DEV_REV` (default 0x03). Writes to both are dropped.
- R6: Index 0x07 is a full-byte read/write logical-device selector. All per-device registers (0x30, 0x60, 0x61) act on the device it selects.
- R7: With logical device 9 selected, bit 0 of index 0x30 sets `mbx_active`. That register reads back with bits 7:1 as zero.
- R8: With logical device 9 selected, index 0x60 holds `mbx_base[15:8]` and index 0x61 holds `mbx_base[7:0]`. Both read back.
- R9: With any other logical device selected, indexes 0x30, 0x60 and 0x61 read 0x00, and writes to them leave `mbx_active` and `mbx_base` unchanged.
- R10: Indexes that are not implemented read 0x00, and writes to them are dropped.
- R11: `io_rdata` updates only at a clock edge where `io_rd` is high and the address is the index or data port. It reflects the state before any write in that same cycle. Reads of other addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| mbx_active | output | 1 | Mailbox device activate bit |
| mbx_base | output | 16 | Mailbox base I/O address |

## Verification
A wrong lock state shows up at the very next port read. The index port returns 0xFF instead of the stored index, or the reverse, one cycle after the read strobe. A corrupted device selector or a bank decode fault shows up in two ways: either `mbx_active` or `mbx_base` changes on the cycle after a write that should have been dropped, or a banked register reads back a stale or zero byte. The bench runs a model of the lock, index, selector and mailbox state alongside the design. It compares every read and both mailbox outputs after each access. A fault is therefore caught within one access of the point where the state diverges.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int BYTE_W = 8;
  localparam int BASE_W = 16;

  localparam logic [BYTE_W-1:0] KEY_OPEN    = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_CLOSE   = 8'hAA;
  localparam logic [BYTE_W-1:0] IDX_LDN     = 8'h07;
  localparam logic [BYTE_W-1:0] IDX_ID      = 8'h20;
  localparam logic [BYTE_W-1:0] IDX_REV     = 8'h21;
  localparam logic [BYTE_W-1:0] IDX_ACT     = 8'h30;
  localparam logic [BYTE_W-1:0] IDX_BASE_HI = 8'h60;
  localparam logic [BYTE_W-1:0] IDX_BASE_LO = 8'h61;
  localparam logic [BYTE_W-1:0] FILL_LOCKED = 8'hFF;
  localparam logic [BYTE_W-1:0] FILL_EMPTY  = 8'h00;

  typedef enum logic {LK_CLOSED = 1'b0, LK_OPEN = 1'b1} lock_st_t;

  typedef struct packed {
    logic idx_wr;
    logic idx_rd;
    logic dat_wr;
    logic dat_rd;
  } acc_t;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h002E
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output acc_t              acc
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = IDX_ADDR + 1'b1;

  logic hit_idx, hit_dat;
  assign hit_idx = (io_addr == IDX_ADDR);
  assign hit_dat = (io_addr == DAT_ADDR);

  always_comb begin
    acc.idx_wr = io_wr & hit_idx;
    acc.idx_rd = io_rd & hit_idx;
    acc.dat_wr = io_wr & hit_dat;
    acc.dat_rd = io_rd & hit_dat;
  end
endmodule

// File: rtl/cfgp_lock.sv
module cfgp_lock
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              unlocked,
  output logic [BYTE_W-1:0] index
);
  lock_st_t          st_q;
  logic [BYTE_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= LK_CLOSED;
      idx_q <= '0;
    end else if (idx_wr) begin
      if (st_q == LK_CLOSED) begin
        if (wdata == KEY_OPEN) st_q <= LK_OPEN;
      end else if (wdata == KEY_CLOSE) begin
        st_q <= LK_CLOSED;
      end else begin
        idx_q <= wdata;
      end
    end
  end

  assign unlocked = (st_q == LK_OPEN);
  assign index    = idx_q;

  p_open_key_r2: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && idx_wr && wdata == KEY_OPEN) |=> unlocked);
  p_locked_idx_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!unlocked) |=> $stable(index));
  p_close_key_r3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked);
  p_stay_open_r3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !(idx_wr && wdata == KEY_CLOSE)) |=> unlocked);
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ID       = 8'h4D,
  parameter logic [BYTE_W-1:0] DEV_REV      = 8'h03,
  parameter logic [BYTE_W-1:0] MBX_LDN      = 8'h09,
  parameter logic [BASE_W-1:0] MBX_BASE_RST = 16'h0800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] index,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              mbx_active,
  output logic [BASE_W-1:0] mbx_base
);
  localparam int HALF = BASE_W / 2;

  logic [BYTE_W-1:0] ldn_q;
  logic              act_q;
  logic [BASE_W-1:0] base_q;
  logic              bank_mbx;

  assign bank_mbx = (ldn_q == MBX_LDN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q  <= '0;
      act_q  <= 1'b0;
      base_q <= MBX_BASE_RST;
    end else if (wr_en) begin
      unique case (index)
        IDX_LDN:     ldn_q <= wdata;
        IDX_ACT:     if (bank_mbx) act_q <= wdata[0];
        IDX_BASE_HI: if (bank_mbx) base_q[BASE_W-1:HALF] <= wdata;
        IDX_BASE_LO: if (bank_mbx) base_q[HALF-1:0] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_byte = FILL_EMPTY;
    unique case (index)
      IDX_LDN:     rd_byte = ldn_q;
      IDX_ID:      rd_byte = DEV_ID;
      IDX_REV:     rd_byte = DEV_REV;
      IDX_ACT:     if (bank_mbx) rd_byte = {{(BYTE_W-1){1'b0}}, act_q};
      IDX_BASE_HI: if (bank_mbx) rd_byte = base_q[BASE_W-1:HALF];
      IDX_BASE_LO: if (bank_mbx) rd_byte = base_q[HALF-1:0];
      default: ;
    endcase
  end

  assign mbx_active = act_q;
  assign mbx_base   = base_q;

  p_ldn_only_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && index == IDX_LDN) |=> $stable(ldn_q));
  p_act_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && index == IDX_ACT && ldn_q == MBX_LDN) |=> (mbx_active == $past(wdata[0])));
  p_base_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || ldn_q != MBX_LDN) |=> ($stable(mbx_base) && $stable(mbx_active)));
  p_act_zero_pad_r7: assert property (@(posedge clk) disable iff (rst)
    (index == IDX_ACT) |-> (rd_byte[BYTE_W-1:1] == '0));
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
  import cfgp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR     = 16'h002E,
  parameter logic [7:0]        DEV_REV      = 8'h03,
  parameter logic [7:0]        MBX_LDN      = 8'h09,
  parameter logic [15:0]       MBX_BASE_RST = 16'h0800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              mbx_active,
  output logic [15:0]       mbx_base
);
  acc_t              acc;
  logic              unlocked;
  logic [BYTE_W-1:0] index;
  logic [BYTE_W-1:0] reg_byte;
  logic [BYTE_W-1:0] rdata_q;

  cfgp_decode #(.ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR)) u_decode (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .acc     (acc)
  );

  cfgp_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (acc.idx_wr),
    .wdata    (io_wdata),
    .unlocked (unlocked),
    .index    (index)
  );

  cfgp_regs #(
    .DEV_ID       (8'h4D),
    .DEV_REV      (DEV_REV),
    .MBX_LDN      (MBX_LDN),
    .MBX_BASE_RST (MBX_BASE_RST)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (acc.dat_wr & unlocked),
    .index      (index),
    .wdata      (io_wdata),
    .rd_byte    (reg_byte),
    .mbx_active (mbx_active),
    .mbx_base   (mbx_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= FILL_LOCKED;
    end else if (acc.idx_rd) begin
      rdata_q <= unlocked ? index : FILL_LOCKED;
    end else if (acc.dat_rd) begin
      rdata_q <= unlocked ? reg_byte : FILL_LOCKED;
    end
  end

  assign io_rdata = rdata_q;

  p_locked_read_ff_r4: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && (acc.idx_rd || acc.dat_rd)) |=> (io_rdata == FILL_LOCKED));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(acc.idx_rd || acc.dat_rd) |=> $stable(io_rdata));
  p_one_port_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc.idx_wr | acc.idx_rd, acc.dat_wr | acc.dat_rd}));
  p_index_readback_r3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && acc.idx_rd) |=> (io_rdata == $past(index)));
endmodule

// File: tb/cfgp_top_bench.sv
module cfgp_top_bench;
  localparam int          CLK_P = 10;
  localparam logic [15:0] IA    = 16'h002E;
  localparam logic [15:0] DA    = 16'h002F;
  localparam logic [7:0]  REV   = 8'h03;
  localparam logic [15:0] BRST  = 16'h0800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        mbx_active;
  logic [15:0] mbx_base;

  int n_chk = 0, n_err = 0;

  // bench model
  logic        m_open;
  logic [7:0]  m_idx, m_ldn;
  logic        m_act;
  logic [15:0] m_base;

  always #(CLK_P/2) clk = ~clk;

  cfgp_top u_cfgp_top (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mbx_active(mbx_active), .mbx_base(mbx_base)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data();
    if (!m_open) return 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h4D;
      8'h21: return REV;
      8'h30: return (m_ldn == 8'h09) ? {7'b0, m_act} : 8'h00;
      8'h60: return (m_ldn == 8'h09) ? m_base[15:8] : 8'h00;
      8'h61: return (m_ldn == 8'h09) ? m_base[7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_index();
    return m_open ? m_idx : 8'hFF;
  endfunction

  task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
    if (a == IA) begin
      if (!m_open) begin
        if (d == 8'h55) m_open = 1'b1;
      end else if (d == 8'hAA) m_open = 1'b0;
      else m_idx = d;
    end else if (a == DA && m_open) begin
      case (m_idx)
        8'h07: m_ldn = d;
        8'h30: if (m_ldn == 8'h09) m_act = d[0];
        8'h60: if (m_ldn == 8'h09) m_base[15:8] = d;
        8'h61: if (m_ldn == 8'h09) m_base[7:0] = d;
        default: ;
      endcase
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    do_rd(a, d);
    chk(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic out_chk(input string req);
    chk({req, " mbx_active"}, {15'b0, mbx_active}, {15'b0, m_act});
    chk({req, " mbx_base"}, mbx_base, m_base);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    m_open = 1'b0; m_idx = 8'h00; m_ldn = 8'h00; m_act = 1'b0; m_base = BRST;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    out_chk("R1");
    rd_chk("R1 locked index", IA, 8'hFF);
    rd_chk("R4 locked data read", DA, 8'hFF);
    // R2 non-key while locked ignored
    do_wr(IA, 8'h20);
    rd_chk("R2 stray key ignored", IA, 8'hFF);
    do_wr(IA, 8'h55);
    rd_chk("R2 index after unlock", IA, 8'h00);
    // R5
    do_wr(IA, 8'h20);
    rd_chk("R3 index readback", IA, 8'h20);
    rd_chk("R5 id", DA, 8'h4D);
    do_wr(DA, 8'h12);
    rd_chk("R5 id write dropped", DA, 8'h4D);
    do_wr(IA, 8'h21);
    rd_chk("R5 rev", DA, REV);
    // R6
    do_wr(IA, 8'h07); do_wr(DA, 8'h09);
    rd_chk("R6 selector", DA, 8'h09);
    // R7
    do_wr(IA, 8'h30); do_wr(DA, 8'hFF);
    rd_chk("R7 act readback", DA, 8'h01);
    chk("R7 active out", {15'b0, mbx_active}, 16'h0001);
    // R8
    do_wr(IA, 8'h60); do_wr(DA, 8'h12);
    do_wr(IA, 8'h61); do_wr(DA, 8'h34);
    chk("R8 base", mbx_base, 16'h1234);
    rd_chk("R8 low readback", DA, 8'h34);
    // R9
    do_wr(IA, 8'h07); do_wr(DA, 8'h03);
    do_wr(IA, 8'h60); do_wr(DA, 8'h99);
    rd_chk("R9 other bank read", DA, 8'h00);
    do_wr(IA, 8'h30); do_wr(DA, 8'h00);
    out_chk("R9");
    // R10
    do_wr(IA, 8'h45); do_wr(DA, 8'h5A);
    rd_chk("R10 unimpl read", DA, 8'h00);
    out_chk("R10");
    // R11: other address read leaves rdata
    do_rd(IA, prev);
    rd_chk("R11 foreign read", 16'h0080, prev);
    // R3/R4 close, locked data write ignored
    do_wr(IA, 8'h07); do_wr(DA, 8'h09);
    do_wr(IA, 8'h61);
    do_wr(IA, 8'hAA);
    rd_chk("R3 locked index", IA, 8'hFF);
    do_wr(DA, 8'h77);
    out_chk("R4 locked write");
    do_wr(IA, 8'h55);
    rd_chk("R3 index kept", IA, 8'h61);
    rd_chk("R4 base low kept", DA, 8'h34);

    // constrained random against model
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 6;
      if (op < 2) begin
        int k = $urandom % 10;
        logic [7:0] v;
        case (k)
          0: v = 8'h55; 1: v = 8'hAA; 2: v = 8'h07; 3: v = 8'h20;
          4: v = 8'h21; 5: v = 8'h30; 6: v = 8'h60; 7: v = 8'h61;
          default: v = 8'($urandom);
        endcase
        do_wr(IA, v);
      end else if (op < 4) begin
        logic [7:0] v;
        v = (m_idx == 8'h07 && ($urandom % 2) == 0) ? 8'h09 : 8'($urandom);
        do_wr(DA, v);
      end else if (op == 4) begin
        rd_chk("R3 random index", IA, exp_index());
      end else begin
        rd_chk("R8 random data", DA, exp_data());
      end
      out_chk("R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule